// File: doc/BRIEF.md
# Power Partition Gating Register Slice

This block is a register slice in a power-management unit. It controls sixteen power partitions, and each partition is gated on its own. Software drives the block through a plain register read/write port. It changes the power of a partition by writing a toggle command that names the partition and carries a start flag. The block does not take an absolute on/off value. It inverts the partition's power state once a build-time settle interval has elapsed, and the new state then shows in a read-only status word.

Each partition also has an isolation clamp. Clamps are asserted out of reset and whenever the partition is powered down. Software releases a clamp by writing a one-hot word to a write-only release register. For backward compatibility, the release register exchanges the bit positions of the PCIe partition (index 3) and the video-decoder partition (index 4).

The slice has no streaming data path, so the bus has no back-pressure: every access completes in the cycle it is presented. Read data is combinational from the address.

Top module: `pgate_regs`

## Requirements
- R1: After reset, `pwr_en` is all zero, `clamp_on` is all ones, and the status word reads zero.
- R2: A write to offset 0x30 with bit 8 set, bits [31:9] zero and an index below 16 in bits [7:0] inverts the power state of that partition. It does not set an absolute value.
- R3: A write to offset 0x30 with bit 8 clear changes nothing.
- R4: A toggle write whose index is 16 or more, or whose bits [31:9] are not all zero, changes nothing.
- R5: The power change appears on `pwr_en` and in the status word exactly SETTLE_CYCLES clock edges after the edge that accepted the toggle, and not one edge earlier.
- R6: While a partition is settling, further toggles to that partition are ignored.
- R7: A read of offset 0x38 returns, in bit N, 1 when partition N is powered and 0 when it is gated.
- R8: A write of a one-hot word to offset 0x34 releases the clamp of the named powered partition on the next edge. A word that is not one-hot, or that names a bit of 16 or above, is ignored.
- R9: In the release word, bit 3 releases partition 4 and bit 4 releases partition 3.
- R10: A clamp re-asserts on the edge its partition's power turns off. A release aimed at an unpowered partition is ignored.
- R11: Reads of offsets 0x30 and 0x34 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read strobe |
| pwr_en | output | 16 | Power enable per partition |
| clamp_on | output | 16 | Isolation clamp per partition, 1 = clamped |

## Verification
The bench checks that each toggle is a pure inversion. A design that wrote an absolute value would leave a powered partition on instead of turning it off. It also checks the exact cycle of the state change, so a settle counter that is off by one edge fails. A second toggle sent one cycle into settling must be dropped; a design that accepts it would cancel the first toggle and leave the partition unchanged. The swapped release bits for partitions 3 and 4 are tested in both directions, and so are releases aimed at unpowered partitions. A design without the swap, or one that lets a clamp drop on a gated partition, shows the wrong `clamp_on` bit.

// File: rtl/pgate_pkg.sv
package pgate_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 32;
  localparam int START_BIT = 8;
  localparam logic [ADDR_W-1:0] OFF_TOGGLE = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_CLAMP  = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h38;
endpackage

// File: rtl/pgate_cmd_decode.sv
module pgate_cmd_decode
  import pgate_pkg::*;
#(
  parameter int NPART    = 16,
  parameter int PCIE_IDX = 3,
  parameter int VDEC_IDX = 4
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [NPART-1:0]  toggle_hit,
  output logic [NPART-1:0]  release_mask
);
  localparam int IDX_FIELD_W = START_BIT;

  logic                   tog_wr;
  logic                   clr_wr;
  logic [IDX_FIELD_W-1:0] tog_idx;
  logic                   tog_ok;
  logic                   rel_onehot;

  assign tog_wr  = bus_sel && bus_we && (bus_addr == OFF_TOGGLE);
  assign clr_wr  = bus_sel && bus_we && (bus_addr == OFF_CLAMP);
  assign tog_idx = bus_wdata[IDX_FIELD_W-1:0];

  // start flag set, reserved field zero, index in range
  assign tog_ok = tog_wr && bus_wdata[START_BIT]
                  && (bus_wdata[DATA_W-1:START_BIT+1] == '0)
                  && (int'(tog_idx) < NPART);

  assign rel_onehot = clr_wr && (bus_wdata != '0)
                      && ((bus_wdata & (bus_wdata - 1'b1)) == '0);

  for (genvar i = 0; i < NPART; i++) begin : g_part
    localparam int SRC = (i == PCIE_IDX) ? VDEC_IDX :
                         (i == VDEC_IDX) ? PCIE_IDX : i;
    assign toggle_hit[i]   = tog_ok && (int'(tog_idx) == i);
    assign release_mask[i] = rel_onehot && bus_wdata[SRC];
  end
endmodule

// File: rtl/pgate_partition.sv
module pgate_partition #(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic toggle_req,
  input  logic release_req,
  output logic pwr_on,
  output logic clamp_on
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

  logic             pwr_q;
  logic             clamp_q;
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flip;

  assign flip = busy_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (toggle_req) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(SETTLE_CYCLES);
      end
    end else if (flip) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_q   <= 1'b0;
      clamp_q <= 1'b1;
    end else begin
      if (flip) pwr_q <= ~pwr_q;
      if (flip && pwr_q)             clamp_q <= 1'b1;
      else if (release_req && pwr_q) clamp_q <= 1'b0;
    end
  end

  assign pwr_on   = pwr_q;
  assign clamp_on = clamp_q;

  AST_FLIP_ONLY_SETTLING: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy_q) |-> $stable(pwr_q)); // R5
  AST_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0)); // R5
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && toggle_req && !flip) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1)); // R6
  AST_CLAMP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_q |-> clamp_q); // R10
endmodule

// File: rtl/pgate_regs.sv
module pgate_regs
  import pgate_pkg::*;
#(
  parameter int NPART         = 16,
  parameter int SETTLE_CYCLES = 4,
  parameter int PCIE_IDX      = 3,
  parameter int VDEC_IDX      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NPART-1:0]  pwr_en,
  output logic [NPART-1:0]  clamp_on
);
  logic [NPART-1:0] toggle_hit;
  logic [NPART-1:0] release_mask;

  pgate_cmd_decode #(
    .NPART(NPART), .PCIE_IDX(PCIE_IDX), .VDEC_IDX(VDEC_IDX)
  ) dec_i (
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .toggle_hit(toggle_hit),
    .release_mask(release_mask)
  );

  for (genvar i = 0; i < NPART; i++) begin : g_part
    pgate_partition #(.SETTLE_CYCLES(SETTLE_CYCLES)) part_i (
      .clk(clk), .rst_n(rst_n),
      .toggle_req(toggle_hit[i]), .release_req(release_mask[i]),
      .pwr_on(pwr_en[i]), .clamp_on(clamp_on[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we && bus_addr == OFF_STATUS)
      bus_rdata = DATA_W'(pwr_en);
  end

  AST_TOGGLE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(toggle_hit)); // R2
  AST_RELEASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(release_mask)); // R8
  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && (bus_addr == OFF_TOGGLE || bus_addr == OFF_CLAMP))
      |-> (bus_rdata == '0)); // R11
endmodule

// File: tb/pgate_regs_tb.sv
module pgate_regs_tb_top;
  localparam int SETTLE = 4;
  localparam int NVEC   = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pwr_en;
  logic [15:0] clamp_on;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pgate_regs #(.SETTLE_CYCLES(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwr_en(pwr_en), .clamp_on(clamp_on)
  );

  // {addr, wdata, expected pwr_en, expected clamp_on} after settling
  localparam logic [71:0] VEC [0:NVEC-1] = '{
    {8'h30, 32'h0000_0105, 16'h0020, 16'hFFFF}, // R2 power on p5
    {8'h34, 32'h0000_0020, 16'h0020, 16'hFFDF}, // R8 release p5
    {8'h30, 32'h0000_0005, 16'h0020, 16'hFFDF}, // R3 no start flag
    {8'h30, 32'h0000_0110, 16'h0020, 16'hFFDF}, // R4 index 16
    {8'h30, 32'h0000_0103, 16'h0028, 16'hFFDF}, // R2 power on p3
    {8'h30, 32'h0000_0104, 16'h0038, 16'hFFDF}, // R2 power on p4
    {8'h34, 32'h0000_0008, 16'h0038, 16'hFFCF}, // R9 bit3 frees p4
    {8'h34, 32'h0000_0010, 16'h0038, 16'hFFC7}, // R9 bit4 frees p3
    {8'h30, 32'h0000_0105, 16'h0018, 16'hFFE7}, // R2 R10 p5 off, reclamp
    {8'h34, 32'h0000_0020, 16'h0018, 16'hFFE7}, // R10 release while off
    {8'h30, 32'h0000_010F, 16'h8018, 16'hFFE7}, // R2 power on p15
    {8'h30, 32'h0000_01FF, 16'h8018, 16'hFFE7}  // R4 index 255
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 pwr_en", 32'(pwr_en), 32'h0);
    chk("R1 clamp_on", 32'(clamp_on), 32'hFFFF);
    rd(8'h38, rv); chk("R1 status", rv, 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      wr(VEC[v][71:64], VEC[v][63:32]);
      idle(SETTLE + 1);
      chk($sformatf("vec%0d pwr_en", v), 32'(pwr_en), 32'(VEC[v][31:16]));
      chk($sformatf("vec%0d clamp_on", v), 32'(clamp_on), 32'(VEC[v][15:0]));
      rd(8'h38, rv); chk($sformatf("R7 vec%0d status", v), rv, 32'(VEC[v][31:16]));
    end

    // R4 reserved bits set: ignored
    wr(8'h30, 32'h0001_0101);
    idle(SETTLE + 1);
    chk("R4 reserved bits", 32'(pwr_en), 32'h8018);

    // R8 non-one-hot release ignored (p15 powered)
    wr(8'h34, 32'h0000_8008);
    idle(1);
    chk("R8 not one-hot", 32'(clamp_on), 32'hFFE7);

    // R5 exact settle timing on p1
    wr(8'h30, 32'h0000_0101);
    idle(SETTLE - 1);
    chk("R5 one edge early", 32'(pwr_en[1]), 32'h0);
    idle(1);
    chk("R5 on time", 32'(pwr_en[1]), 32'h1);

    // R6 second toggle during settling dropped (p2)
    wr(8'h30, 32'h0000_0102);
    wr(8'h30, 32'h0000_0102);
    idle(SETTLE + 2);
    chk("R6 busy toggle ignored", 32'(pwr_en), 32'h801E);

    // R11 write-only registers read zero
    rd(8'h30, rv); chk("R11 toggle reads zero", rv, 32'h0);
    rd(8'h34, rv); chk("R11 clamp reads zero", rv, 32'h0);

    // R1 reset in mid-run
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    chk("R1 pwr_en after reset", 32'(pwr_en), 32'h0);
    chk("R1 clamp_on after reset", 32'(clamp_on), 32'hFFFF);
    rd(8'h38, rv); chk("R1 status after reset", rv, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule